// File: doc/BRIEF.md
# Eight-Input Masked Interrupt Collector

This block gathers eight level-free interrupt requests into one pending-request byte and forwards a single combined interrupt line to a parent interrupt controller. Software sees it through a small byte-wide register window: it reads the pending-request byte, writes an inverted enable mask, and writes an acknowledge command that names one request bit by index to clear. A second controller half is present only as placeholder registers: its mask write is accepted and held, and its reads return zero.

The combined line is held in a two-state machine, `ST_QUIET` and `ST_POSTING`. The transition RAISE (`ST_QUIET` to `ST_POSTING`) fires when a request input sets a bit, or when a mask write leaves an enabled pending request. The transition DROP (`ST_POSTING` to `ST_QUIET`) fires when a mask write, an acknowledge write or a request-clear input leaves no enabled pending request. With no such event the state holds. A newly set request raises the line even when its input is disabled; only a later re-evaluating event brings it back down.

Register window (3-bit address): 0 pending requests (read), 1 primary mask (write), 2 acknowledge (write), 3 secondary requests (read, zero), 4 secondary mask (write; read returns zero). Every other direction and address pair is unmapped.

Top module: `cascade_irq_ctl`

## Requirements
- R1: After reset the pending-request byte is 0x00, all inputs are disabled, the interrupt line is low and the error flag is low.
- R2: A read at address 0 returns the pending-request byte in the same cycle, including bits whose inputs are disabled.
- R3: A write at address 1 stores the bitwise inverse of the data as the enable mask, so a data bit of 1 disables that input.
- R4: After a write at address 1, the line is high in the next cycle if any pending request is enabled, and low if none is.
- R5: A write at address 2 clears the pending bit whose index is data[3:0]; indices 8 to 15 clear nothing; the line drops in the next cycle if no enabled request remains.
- R6: A nonzero req_set pulse ORs its bits into the pending byte and raises the line in the next cycle, whether or not those inputs are enabled.
- R7: A req_clr pulse clears its bits (a bit in both req_set and req_clr ends cleared) and drops the line in the next cycle if no enabled request remains.
- R8: Reads at addresses 3 and 4 return 0x00; a write at address 4 changes neither the line nor the pending byte and does not set the error flag.
- R9: A read at 1, 2, 5, 6 or 7, or a write at 0, 3, 5, 6 or 7, returns 0x00 for a read and sets the error flag, which stays set until reset.
- R10: In a cycle with no req_set bit, no req_clr bit, no mask write and no acknowledge write, the line keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid while rd_en is high |
| req_set | input | 8 | Request bits to set, one cycle pulse |
| req_clr | input | 8 | Request bits to clear, one cycle pulse |
| irq_out | output | 1 | Combined interrupt line to the parent |
| err_flag | output | 1 | Sticky unmapped-access flag |

## Verification
The hardest situation to reach is the line sitting high while no enabled request exists, because only a set pulse on a disabled input creates it and nothing clears it until a re-evaluating event arrives. The stimulus reaches it straight after reset, when every input is still disabled, by pulsing req_set, then proves the stale line falls on an unrelated req_clr pulse. A later set on a disabled input while another input is enabled repeats the case from the mask side, and same-cycle set and clear of one bit checks that clear wins without a spurious raise.

// File: rtl/cic_pkg.sv
package cic_pkg;
    localparam int ADDR_W    = 3;
    localparam int ACK_IDX_W = 4;

    localparam int A_PRI_REQ  = 0;
    localparam int A_PRI_MASK = 1;
    localparam int A_ACK      = 2;
    localparam int A_SEC_REQ  = 3;
    localparam int A_SEC_MASK = 4;

    typedef enum logic {
        ST_QUIET   = 1'b0,
        ST_POSTING = 1'b1
    } post_state_t;
endpackage

// File: rtl/cic_regs.sv
module cic_regs
    import cic_pkg::*;
#(
    parameter int N_REQ  = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [N_REQ-1:0]  req_set,
    input  logic [N_REQ-1:0]  req_clr,
    output logic [DATA_W-1:0] rdata,
    output logic              err_flag,
    output logic [DATA_W-1:0] sec_mask,
    output logic              raise_evt,
    output logic              drop_evt
);
    logic [N_REQ-1:0]  req_q, en_q, req_next, en_next, ack_vec;
    logic [DATA_W-1:0] sec_q;
    logic              err_q;
    logic              mask_wr, ack_wr, sec_wr, wr_ok, rd_ok, bad_acc, live_next;

    assign mask_wr = wr_en && (addr == ADDR_W'(A_PRI_MASK));
    assign ack_wr  = wr_en && (addr == ADDR_W'(A_ACK));
    assign sec_wr  = wr_en && (addr == ADDR_W'(A_SEC_MASK));
    assign wr_ok   = mask_wr || ack_wr || sec_wr;
    assign rd_ok   = (addr == ADDR_W'(A_PRI_REQ)) || (addr == ADDR_W'(A_SEC_REQ)) ||
                     (addr == ADDR_W'(A_SEC_MASK));
    assign bad_acc = (wr_en && !wr_ok) || (rd_en && !rd_ok);

    // one-hot acknowledge decode; indices beyond N_REQ select nothing
    for (genvar i = 0; i < N_REQ; i++) begin : g_ack
        assign ack_vec[i] = ack_wr && (wdata[ACK_IDX_W-1:0] == ACK_IDX_W'(i));
    end

    // clear beats set, set beats acknowledge
    assign req_next  = (req_q & ~ack_vec & ~req_clr) | (req_set & ~req_clr);
    assign en_next   = mask_wr ? ~wdata[N_REQ-1:0] : en_q;
    assign live_next = |(req_next & en_next);

    assign raise_evt = (|(req_set & ~req_clr)) || (mask_wr && live_next);
    assign drop_evt  = (mask_wr || ack_wr || (|req_clr)) && !live_next;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q <= '0;
            en_q  <= '0;
            sec_q <= '0;
            err_q <= 1'b0;
        end else begin
            req_q <= req_next;
            en_q  <= en_next;
            if (sec_wr)  sec_q <= wdata;
            if (bad_acc) err_q <= 1'b1;
        end
    end

    always_comb begin
        rdata = '0;
        if (rd_en && (addr == ADDR_W'(A_PRI_REQ)))
            rdata = DATA_W'(req_q);
    end

    assign err_flag = err_q;
    assign sec_mask = sec_q;
endmodule

// File: rtl/cic_post_fsm.sv
module cic_post_fsm
    import cic_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic raise_evt,
    input  logic drop_evt,
    output logic irq_out
);
    post_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_QUIET:   if (raise_evt) state_d = ST_POSTING;          // RAISE
            ST_POSTING: if (!raise_evt && drop_evt) state_d = ST_QUIET; // DROP
            default:    state_d = ST_QUIET;
        endcase
    end

    always_comb begin
        irq_out = (state_q == ST_POSTING);
    end
endmodule

// File: rtl/cascade_irq_ctl.sv
module cascade_irq_ctl
    import cic_pkg::*;
#(
    parameter int N_REQ  = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [N_REQ-1:0]  req_set,
    input  logic [N_REQ-1:0]  req_clr,
    output logic              irq_out,
    output logic              err_flag
);
    logic              raise_evt, drop_evt;
    logic [DATA_W-1:0] sec_mask_w;

    cic_regs #(.N_REQ(N_REQ), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .req_set(req_set), .req_clr(req_clr), .rdata(rdata),
        .err_flag(err_flag), .sec_mask(sec_mask_w),
        .raise_evt(raise_evt), .drop_evt(drop_evt)
    );

    cic_post_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .raise_evt(raise_evt), .drop_evt(drop_evt),
        .irq_out(irq_out)
    );
endmodule

// File: rtl/cascade_irq_ctl_chk.sv
module cascade_irq_ctl_chk
    import cic_pkg::*;
#(
    parameter int N_REQ  = 8,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] rdata,
    input logic [N_REQ-1:0]  req_set,
    input logic [N_REQ-1:0]  req_clr,
    input logic              irq_out,
    input logic              err_flag,
    input logic [DATA_W-1:0] sec_mask_w
);
    logic wr_mask, wr_ack, wr_sec, unmapped;
    assign wr_mask  = wr_en && (addr == ADDR_W'(A_PRI_MASK));
    assign wr_ack   = wr_en && (addr == ADDR_W'(A_ACK));
    assign wr_sec   = wr_en && (addr == ADDR_W'(A_SEC_MASK));
    assign unmapped = (wr_en && !(wr_mask || wr_ack || wr_sec)) ||
                      (rd_en && !((addr == ADDR_W'(A_PRI_REQ)) ||
                                  (addr == ADDR_W'(A_SEC_REQ)) ||
                                  (addr == ADDR_W'(A_SEC_MASK))));

    p_all_masked_drops_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_mask && (wdata[N_REQ-1:0] == {N_REQ{1'b1}}) && (req_set == '0)) |=> !irq_out);

    p_set_raises_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|(req_set & ~req_clr)) |=> irq_out);

    p_sec_read_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && ((addr == ADDR_W'(A_SEC_REQ)) || (addr == ADDR_W'(A_SEC_MASK)))) |-> (rdata == '0));

    p_sec_mask_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_sec |=> $stable(sec_mask_w));

    p_unmapped_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
        unmapped |=> err_flag);

    p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag);

    p_quiet_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_out && (req_set == '0) && !wr_mask) |=> !irq_out);

    p_posting_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out && (req_clr == '0) && !wr_mask && !wr_ack) |=> irq_out);
endmodule

bind cascade_irq_ctl cascade_irq_ctl_chk #(.N_REQ(N_REQ), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/cascade_irq_ctl_tb.sv
module cascade_irq_ctl_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0, rdata;
    logic [7:0] req_set = '0, req_clr = '0;
    logic       irq_out, err_flag;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cascade_irq_ctl u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .req_set(req_set), .req_clr(req_clr),
        .irq_out(irq_out), .err_flag(err_flag)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk); rd_en = 1'b1; addr = a;
        #1 d = rdata;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic pulse(input logic [7:0] s, input logic [7:0] c);
        @(negedge clk); req_set = s; req_clr = c;
        @(negedge clk); req_set = '0; req_clr = '0;
    endtask

    task automatic t_reset;
        logic [7:0] d;
        chk("R1 irq after reset", {7'd0, irq_out}, 8'h00);
        chk("R1 err after reset", {7'd0, err_flag}, 8'h00);
        rd(3'd0, d);
        chk("R1 pending after reset", d, 8'h00);
    endtask

    task automatic t_disabled_set;
        logic [7:0] d;
        pulse(8'h05, 8'h00);
        chk("R6 irq on disabled set", {7'd0, irq_out}, 8'h01);
        rd(3'd0, d);
        chk("R6 pending after set", d, 8'h05);
        pulse(8'h00, 8'h80);
        chk("R7/R1 clear drops with all disabled", {7'd0, irq_out}, 8'h00);
        rd(3'd0, d);
        chk("R7 unrelated clear keeps pending", d, 8'h05);
    endtask

    task automatic t_mask;
        logic [7:0] d;
        wr(3'd1, 8'hFE);
        chk("R4 mask enable raises", {7'd0, irq_out}, 8'h01);
        rd(3'd0, d);
        chk("R2 read ignores mask", d, 8'h05);
        wr(3'd1, 8'hFF);
        chk("R3/R4 all-ones mask drops", {7'd0, irq_out}, 8'h00);
        wr(3'd1, 8'hFB);
        chk("R3 inverted enable of bit 2 raises", {7'd0, irq_out}, 8'h01);
    endtask

    task automatic t_ack;
        logic [7:0] d;
        wr(3'd2, 8'h10);
        rd(3'd0, d);
        chk("R5 ack uses low nibble", d, 8'h04);
        chk("R5 irq kept with enabled left", {7'd0, irq_out}, 8'h01);
        wr(3'd2, 8'h0A);
        rd(3'd0, d);
        chk("R5 index 10 clears nothing", d, 8'h04);
        wr(3'd2, 8'h02);
        rd(3'd0, d);
        chk("R5 ack clears bit 2", d, 8'h00);
        chk("R5 ack drops irq", {7'd0, irq_out}, 8'h00);
    endtask

    task automatic t_set_clr;
        logic [7:0] d;
        pulse(8'h08, 8'h08);
        rd(3'd0, d);
        chk("R7 clear wins over set", d, 8'h00);
        chk("R7 no raise on cancelled set", {7'd0, irq_out}, 8'h00);
        pulse(8'h08, 8'h00);
        chk("R6 masked set raises", {7'd0, irq_out}, 8'h01);
        pulse(8'h00, 8'h08);
        rd(3'd0, d);
        chk("R7 clear pending", d, 8'h00);
        chk("R7 clear drops irq", {7'd0, irq_out}, 8'h00);
    endtask

    task automatic t_hold_and_sec;
        logic [7:0] d;
        pulse(8'h04, 8'h00);
        repeat (3) @(negedge clk);
        chk("R10 irq holds while idle", {7'd0, irq_out}, 8'h01);
        wr(3'd4, 8'h00);
        chk("R8 secondary mask write no irq change", {7'd0, irq_out}, 8'h01);
        rd(3'd0, d);
        chk("R8 secondary write keeps pending", d, 8'h04);
        rd(3'd3, d);
        chk("R8 secondary request reads zero", d, 8'h00);
        rd(3'd4, d);
        chk("R8 secondary mask reads zero", d, 8'h00);
        chk("R8 no error on secondary", {7'd0, err_flag}, 8'h00);
    endtask

    task automatic t_unmapped;
        logic [7:0] d;
        wr(3'd0, 8'hFF);
        chk("R9 write at 0 flags error", {7'd0, err_flag}, 8'h01);
        rd(3'd0, d);
        chk("R9 unmapped write leaves pending", d, 8'h04);
        rd(3'd6, d);
        chk("R9 unmapped read zero", d, 8'h00);
        repeat (4) @(negedge clk);
        chk("R9 error sticky", {7'd0, err_flag}, 8'h01);
        chk("R10 irq still held", {7'd0, irq_out}, 8'h01);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_disabled_set();
        t_mask();
        t_ack();
        t_set_clr();
        t_hold_and_sec();
        t_unmapped();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule